// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block is the interrupt logic of a 16550-style serial port. The CPU programs a small mask register, the enable register, that selects which of four status sources may interrupt it. The block reads back a one-byte identification value and sees a single interrupt line. The four sources are receive errors, received data, transmitter empty and modem-line change. The receiver, transmitter, FIFOs and modem pins sit outside the block. They feed it level status flags, a character-timeout flag and two flags that describe the FIFO state.

Among the enabled, active sources, the block picks one by fixed rank. It encodes that source into the identification byte, with an active-low "no interrupt" bit in the least significant position. The transmitter-empty source is the only one with internal memory. It is armed by an event, and it is cleared either by a CPU read of the identification byte that reports it or by a write to the transmit data address. Every other source follows its input flag directly. The CPU bus is a plain register port: one strobe for write, one for read, an address and data, with no handshake. Read data is combinational from the address, so a one-cycle read strobe sees the current value.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the identification byte reads 0x01 when fifo_on is 0, and irq is 0.
- R2: A write to address 1 stores data bits 3:0 in the enable register. Bit 0 enables received data and the character timeout, bit 1 enables transmitter empty, bit 2 enables receive errors and bit 3 enables modem change. Bits 7:4 read back as 0 when LOWPWR_BITS is 0.
- R3: A source whose enable bit is 0 has no effect on irq or on the identification byte.
- R4: Identification bits 3:0 read 0110 for receive errors, 0100 for received data, 0010 for transmitter empty, 0000 for modem change, and 0001 when nothing is pending. Bits 5:4 read 0.
- R5: When several enabled sources are active, the reported one follows this rank, highest first: receive errors, received data, character timeout, transmitter empty, modem change.
- R6: A character timeout that is enabled by enable bit 0 reports bits 3:0 = 1100. It ranks just below received data.
- R7: Identification bits 7:6 read 00 when fifo_on is 0, 11 when fifo_on is 1 and fifo_bad is 0, and 10 when both are 1.
- R8: The transmitter-empty source becomes pending one clock after thr_empty rises. It also becomes pending one clock after enable bit 1 goes from 0 to 1 while thr_empty is 1.
- R9: A read strobe at address 2 that reports transmitter empty clears that pending state at the clock edge. A read that reports a higher source leaves it pending.
- R10: A write strobe at address 0 clears a pending transmitter-empty source at the clock edge.
- R11: A write at address 2 changes neither the enable register nor the identification byte.
- R12: irq is 1 exactly when identification bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_addr | input | 3 | Register address: 0 transmit data, 1 enable, 2 identification |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| rx_err | input | 1 | Receive error status is set |
| rx_avail | input | 1 | Received data is waiting |
| thr_empty | input | 1 | Transmit holding register is empty |
| modem_chg | input | 1 | Modem line status has changed |
| char_tmo | input | 1 | Character timeout is pending |
| fifo_on | input | 1 | FIFOs are enabled |
| fifo_bad | input | 1 | FIFOs are enabled but unusable |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench turns on many sources at once under varying masks. A wrong rank or a missing enable gate would show up as the wrong code, for example modem change winning while received data is active, or a masked source still raising irq. The transmitter-empty tests cover three cases. A read that reports that source must clear it. A read taken while a receive error masks it must not clear it, since a design that clears on any read would lose the interrupt. A transmit write must also clear it. Other tests confirm that enabling the source while the transmitter is already empty raises it, and that a write to the identification address leaves the enable register unchanged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source code carried in identification bits 3:1
  typedef enum logic [2:0] {
    SRC_MODEM = 3'b000,
    SRC_TXE   = 3'b001,
    SRC_RXD   = 3'b010,
    SRC_RXERR = 3'b011,
    SRC_TMO   = 3'b110
  } src_code_e;

  // Low nibble of the identification byte: {code, no-pending flag}
  typedef struct packed {
    src_code_e code;
    logic      idle;
  } ident_t;

  localparam ident_t IDENT_IDLE = '{code: SRC_MODEM, idle: 1'b1};

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int DATA_W      = 8,
  parameter int NUM_SRC     = 4,
  parameter bit LOWPWR_BITS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q
);

  localparam int LP_HI = NUM_SRC + 1;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < NUM_SRC || (LOWPWR_BITS && b <= LP_HI)) begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)     mask_q[b] <= 1'b0;
        else if (wr_en) mask_q[b] <= wdata[b];
      end
    end else begin : g_zero
      assign mask_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_txe.sv
module uart_irq_txe (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_flag,
  input  logic enable,
  input  logic thr_write,
  input  logic ident_read_txe,
  output logic pend_q
);

  logic empty_d, enable_d;
  logic arm, drop;

  assign arm  = empty_flag & (~empty_d | (enable & ~enable_d));
  assign drop = thr_write | ident_read_txe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_d  <= 1'b0;
      enable_d <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      empty_d  <= empty_flag;
      enable_d <= enable;
      if (drop)     pend_q <= 1'b0;
      else if (arm) pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic   act_rxerr,
  input  logic   act_rxd,
  input  logic   act_tmo,
  input  logic   act_txe,
  input  logic   act_modem,
  output ident_t ident
);

  always_comb begin
    ident = IDENT_IDLE;
    if (act_rxerr)      ident = '{code: SRC_RXERR, idle: 1'b0};
    else if (act_rxd)   ident = '{code: SRC_RXD,   idle: 1'b0};
    else if (act_tmo)   ident = '{code: SRC_TMO,   idle: 1'b0};
    else if (act_txe)   ident = '{code: SRC_TXE,   idle: 1'b0};
    else if (act_modem) ident = '{code: SRC_MODEM, idle: 1'b0};
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int               ADDR_W      = 3,
  parameter int               DATA_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_THR   = 3'd0,
  parameter logic [ADDR_W-1:0] ADDR_IER   = 3'd1,
  parameter logic [ADDR_W-1:0] ADDR_IIR   = 3'd2,
  parameter bit               LOWPWR_BITS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_err,
  input  logic              rx_avail,
  input  logic              thr_empty,
  input  logic              modem_chg,
  input  logic              char_tmo,
  input  logic              fifo_on,
  input  logic              fifo_bad,
  output logic              irq
);

  localparam int NUM_SRC = 4;
  localparam int ID_W    = $bits(ident_t);
  localparam int PAD_W   = DATA_W - ID_W - 2;

  logic [DATA_W-1:0] ier_q;
  logic              txe_pend;
  logic              act_rxerr, act_rxd, act_tmo, act_txe, act_modem;
  ident_t            ident_w;
  logic [1:0]        fifo_bits;
  logic              read_txe;

  uart_irq_enable #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .LOWPWR_BITS(LOWPWR_BITS)
  ) u_ier (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && bus_addr == ADDR_IER),
    .wdata(bus_wdata), .mask_q(ier_q)
  );

  assign read_txe = bus_rd && bus_addr == ADDR_IIR
                    && !ident_w.idle && ident_w.code == SRC_TXE;

  uart_irq_txe u_txe (
    .clk(clk), .rst_n(rst_n),
    .empty_flag(thr_empty), .enable(ier_q[1]),
    .thr_write(bus_wr && bus_addr == ADDR_THR),
    .ident_read_txe(read_txe),
    .pend_q(txe_pend)
  );

  assign act_rxerr = ier_q[2] & rx_err;
  assign act_rxd   = ier_q[0] & rx_avail;
  assign act_tmo   = ier_q[0] & char_tmo;
  assign act_txe   = ier_q[1] & txe_pend;
  assign act_modem = ier_q[3] & modem_chg;

  uart_irq_arb u_arb (
    .act_rxerr(act_rxerr), .act_rxd(act_rxd), .act_tmo(act_tmo),
    .act_txe(act_txe), .act_modem(act_modem), .ident(ident_w)
  );

  assign irq = act_rxerr | act_rxd | act_tmo | act_txe | act_modem;

  assign fifo_bits = fifo_on ? {1'b1, ~fifo_bad} : 2'b00;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_IER)      bus_rdata = ier_q;
    else if (bus_addr == ADDR_IIR) bus_rdata = {fifo_bits, {PAD_W{1'b0}}, ident_w};
  end

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int               ADDR_W   = 3,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] ADDR_THR = 3'd0,
  parameter logic [ADDR_W-1:0] ADDR_IIR = 3'd2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_err,
  input logic              rx_avail,
  input logic              modem_chg,
  input logic              irq,
  input logic [DATA_W-1:0] ier_q,
  input logic              txe_pend,
  input logic [3:0]        ident
);

  // R12
  irq_matches_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !ident[0]);

  // R5
  rxerr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && rx_err) |-> ident == 4'b0110);

  // R5
  rxd_over_modem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[0] && rx_avail && !(ier_q[2] && rx_err) && modem_chg) |-> ident == 4'b0100);

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[3:0] == 4'b0000) |-> !irq);

  // R10
  thr_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_THR) |=> !txe_pend);

  // R11
  iir_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_IIR) |=> $stable(ier_q));

endmodule

bind uart_irq_ctrl uart_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_THR(ADDR_THR), .ADDR_IIR(ADDR_IIR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .rx_err(rx_err), .rx_avail(rx_avail), .modem_chg(modem_chg),
  .irq(irq), .ier_q(ier_q), .txe_pend(txe_pend), .ident(ident_w)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_err = 0, rx_avail = 0, thr_empty = 0, modem_chg = 0;
  logic       char_tmo = 0, fifo_on = 0, fifo_bad = 0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_err(rx_err), .rx_avail(rx_avail), .thr_empty(thr_empty),
    .modem_chg(modem_chg), .char_tmo(char_tmo), .fifo_on(fifo_on),
    .fifo_bad(fifo_bad), .irq(irq)
  );

  // {enable[3:0], rx_err, rx_avail, modem_chg, char_tmo, fifo_on, fifo_bad, expected id byte}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {4'hF, 4'b0000, 2'b00, 8'h01},
    {4'hF, 4'b1111, 2'b00, 8'h06},
    {4'hF, 4'b0111, 2'b00, 8'h04},
    {4'hF, 4'b0011, 2'b00, 8'h0C},
    {4'hF, 4'b0010, 2'b00, 8'h00},
    {4'h0, 4'b1111, 2'b00, 8'h01},
    {4'hB, 4'b1100, 2'b00, 8'h04},
    {4'h8, 4'b1110, 2'b00, 8'h00},
    {4'h1, 4'b0001, 2'b10, 8'hCC},
    {4'h0, 4'b0000, 2'b11, 8'h81},
    {4'h4, 4'b1000, 2'b10, 8'hC6}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rd_iir(output logic [7:0] v);
    @(negedge clk);
    bus_addr = 3'd2; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(3'd1, v); chk("R1 enable", v, 8'h00);
    peek(3'd2, v); chk("R1 ident", v, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 readback drops reserved bits
    wr(3'd1, 8'hFF);
    peek(3'd1, v); chk("R2 enable readback", v, 8'h0F);

    // R3 R4 R5 R6 R7 R12 vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, {4'h0, VEC[i][17:14]});
      {rx_err, rx_avail, modem_chg, char_tmo} = VEC[i][13:10];
      {fifo_on, fifo_bad} = VEC[i][9:8];
      peek(3'd2, v);
      chk("R3/R4/R5/R6/R7 ident", v, VEC[i][7:0]);
      chk("R12 irq", {7'd0, irq}, {7'd0, ~VEC[i][0]});
    end
    {rx_err, rx_avail, modem_chg, char_tmo, fifo_on, fifo_bad} = '0;

    // R8 rising empty flag arms the source
    wr(3'd1, 8'h02);
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk);
    peek(3'd2, v); chk("R8 armed on rise", v, 8'h02);
    chk("R12 irq txe", {7'd0, irq}, 8'h01);

    // R9 read that reports it clears it
    rd_iir(v); chk("R9 read sees txe", v, 8'h02);
    peek(3'd2, v); chk("R9 cleared after read", v, 8'h01);

    // R10 write to transmit address clears it
    thr_empty = 1'b0; @(negedge clk); thr_empty = 1'b1; @(negedge clk);
    peek(3'd2, v); chk("R8 re-armed", v, 8'h02);
    wr(3'd0, 8'h55);
    peek(3'd2, v); chk("R10 cleared by data write", v, 8'h01);

    // R9 read reporting a higher source keeps it
    wr(3'd1, 8'h06);
    thr_empty = 1'b0; @(negedge clk); thr_empty = 1'b1; rx_err = 1'b1; @(negedge clk);
    rd_iir(v); chk("R9 read sees rx error", v, 8'h06);
    rx_err = 1'b0;
    peek(3'd2, v); chk("R9 txe survives other read", v, 8'h02);
    wr(3'd0, 8'h00);

    // R8 enabling while already empty arms it
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    peek(3'd2, v); chk("R3 masked", v, 8'h01);
    wr(3'd1, 8'h02);
    @(negedge clk);
    peek(3'd2, v); chk("R8 armed on enable", v, 8'h02);

    // R11 write at identification address ignored
    wr(3'd2, 8'hFF);
    peek(3'd1, v); chk("R11 enable unchanged", v, 8'h02);
    peek(3'd2, v); chk("R11 ident unchanged", v, 8'h02);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; thr_empty = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    peek(3'd1, v); chk("R1 enable after reset", v, 8'h00);
    peek(3'd2, v); chk("R1 ident after reset", v, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule